// File: doc/BRIEF.md
# PLL Clock Switchover Sequencer

This block moves the system clock off the internal oscillator and onto a freshly programmed PLL without ever letting an unlocked, unverified or over-fast clock reach the logic. Software, or a boot state machine, places the wanted reference source, the multiplier and divider settings and the final system divider on the inputs, then pulses a start request. The sequencer latches those values. It then walks the clock tree through a fixed order of steps and holds each step for a minimum number of system clock cycles.

The sequencer bypasses the PLL, powers it down, changes the reference source and forces the system divider to /1. It then writes the whole PLL configuration word in a single cycle, and that write also powers the PLL up. It waits for lock, bounded by a timeout. It then asks an external clock comparator to check the raw PLL frequency. If the comparator accepts the frequency, the divider first goes to one code above the target, the PLL output is selected, a settling interval passes, and only then is the target divider applied. A failed frequency check or a lock timeout leaves the PLL bypassed and raises an error flag.

The PLL and the frequency comparator sit outside the block. The done and error flags stay set until the next start request.

Top module: `clk_switch_seq`

## Requirements
- R1: After reset, the PLL clock enable, PLL power enable, reference select (code 0 = internal oscillator), configuration word, write strobe, comparator request, busy, done and error outputs are all 0. The system divider is code 0, which means divide-by-1. Nothing changes until a start request arrives.
- R2: A start request sampled while the block is idle, done or in error latches all inputs. In that same cycle the block clears the PLL clock enable and the done and error flags, and raises busy.
- R3: The PLL power enable falls exactly BYPASS_WAIT cycles after the clock enable was cleared.
- R4: The reference select takes the latched source exactly PWRDN_WAIT cycles after power-down, and only while the PLL is both bypassed and powered down.
- R5: The system divider is set to code 0 exactly SRC_WAIT cycles after the source change. In the following cycle the configuration word {output divider, reference divider, multiplier} (multiplier in the low bits) is presented with a one-cycle write strobe, and the power enable rises in the same cycle.
- R6: The comparator request rises one cycle after lock is sampled high. If lock has not been sampled within LOCK_TIMEOUT cycles after the configuration write, the error flag rises exactly LOCK_TIMEOUT cycles after that write. A lock sampled on the last cycle of the window still counts.
- R7: When the comparator reports a failure, the error flag rises in the cycle the report is sampled, the request drops, and the PLL clock enable and divider /1 remain.
- R8: When the comparator reports a pass, the divider becomes the final code plus one in the cycle the report is sampled. The PLL clock enable rises one cycle later. The clock enable is never 1 while the power enable is 0.
- R9: The final divider code is applied exactly SETTLE_WAIT cycles after the clock enable rises, together with the done flag.
- R10: If the final code is the largest encodable code, the one-above step saturates at that code instead of wrapping.
- R11: A start request while busy is ignored. The sequence timing and the latched source, configuration and divider are unaffected.
- R12: Done and error are never both set, and each stays set until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, one cycle |
| src_sel_i | input | SRC_W | Requested reference source |
| mult_i | input | MULT_W | PLL multiplier |
| refdiv_i | input | REFDIV_W | PLL reference divider |
| odiv_i | input | ODIV_W | PLL output divider |
| final_div_i | input | DIV_W | Target system divider code |
| lock_i | input | 1 | PLL lock status |
| meas_done_i | input | 1 | Comparator result valid |
| meas_ok_i | input | 1 | Comparator result: frequency in range |
| pll_clken_o | output | 1 | Select PLL output as system clock (0 = bypass) |
| pll_pwren_o | output | 1 | PLL power enable |
| ref_src_o | output | SRC_W | Reference source select |
| pll_cfg_o | output | MULT_W+REFDIV_W+ODIV_W | Packed PLL configuration word |
| pll_cfg_wr_o | output | 1 | Configuration write strobe |
| sys_div_o | output | DIV_W | System clock divider code |
| meas_req_o | output | 1 | Request to the frequency comparator |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Switchover completed |
| err_o | output | 1 | Lock timeout or frequency failure |

## Verification
The hardest situations to reach from the ports are the edges of the lock window and the comparator failure after a valid lock, because both depend on how an outside PLL and comparator behave in time. The bench stubs the PLL so that lock rises a programmable number of cycles after the configuration strobe. It shrinks the timeout through a parameter and places lock on the last accepted cycle, and then one cycle late. A comparator stub answers after a chosen delay with a chosen verdict. A sweep over every final divider code of a three-bit divider then reaches the saturating step, and a second start injected mid-sequence tests that busy requests are ignored.

// File: rtl/clk_seq_pkg.sv
package clk_seq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE   = 4'd0,
        ST_BYPASS = 4'd1,
        ST_PWRDN  = 4'd2,
        ST_SRC    = 4'd3,
        ST_PROG   = 4'd4,
        ST_LOCK   = 4'd5,
        ST_CHECK  = 4'd6,
        ST_SWITCH = 4'd7,
        ST_SETTLE = 4'd8,
        ST_DONE   = 4'd9,
        ST_ERR    = 4'd10
    } seq_state_e;

    function automatic int unsigned umax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/clk_seq_timer.sv
module clk_seq_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             zero_o
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = load_val_i;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign zero_o = (cnt_q == '0);

    // R6: an expired window stays expired until reloaded
    p_hold_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && zero_o) |=> zero_o);

endmodule

// File: rtl/clk_seq_divcalc.sv
module clk_seq_divcalc #(
    parameter int DIV_W    = 6,
    parameter int MULT_W   = 7,
    parameter int REFDIV_W = 5,
    parameter int ODIV_W   = 3
) (
    input  logic [DIV_W-1:0]                   final_div_i,
    input  logic [MULT_W-1:0]                  mult_i,
    input  logic [REFDIV_W-1:0]                refdiv_i,
    input  logic [ODIV_W-1:0]                  odiv_i,
    output logic [DIV_W-1:0]                   div_up_o,
    output logic [MULT_W+REFDIV_W+ODIV_W-1:0]  cfg_word_o
);

    localparam logic [DIV_W-1:0] DIV_MAX = '1;

    // one code above target, pinned at the top code
    always_comb begin
        if (final_div_i == DIV_MAX) begin
            div_up_o = DIV_MAX;
        end else begin
            div_up_o = final_div_i + DIV_W'(1);
        end
    end

    // packed so the PLL sees all three fields in one write
    assign cfg_word_o = {odiv_i, refdiv_i, mult_i};

endmodule

// File: rtl/clk_seq_ctrl.sv
module clk_seq_ctrl
    import clk_seq_pkg::*;
#(
    parameter int SRC_W        = 2,
    parameter int CFG_W        = 15,
    parameter int DIV_W        = 6,
    parameter int CNT_W        = 16,
    parameter int BYPASS_WAIT  = 120,
    parameter int PWRDN_WAIT   = 60,
    parameter int SRC_WAIT     = 300,
    parameter int SETTLE_WAIT  = 200,
    parameter int LOCK_TIMEOUT = 65535
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [SRC_W-1:0] src_sel_i,
    input  logic [CFG_W-1:0] cfg_word_i,
    input  logic [DIV_W-1:0] final_div_i,
    input  logic [DIV_W-1:0] div_up_i,
    input  logic             lock_i,
    input  logic             meas_done_i,
    input  logic             meas_ok_i,
    input  logic             tmr_zero_i,
    output logic             tmr_load_o,
    output logic [CNT_W-1:0] tmr_val_o,
    output logic             pll_clken_o,
    output logic             pll_pwren_o,
    output logic [SRC_W-1:0] ref_src_o,
    output logic [CFG_W-1:0] pll_cfg_o,
    output logic             pll_cfg_wr_o,
    output logic [DIV_W-1:0] sys_div_o,
    output logic             meas_req_o,
    output logic             busy_o,
    output logic             done_o,
    output logic             err_o
);

    localparam logic [CNT_W-1:0] BYP_LD    = CNT_W'(BYPASS_WAIT - 1);
    localparam logic [CNT_W-1:0] PWR_LD    = CNT_W'(PWRDN_WAIT - 1);
    localparam logic [CNT_W-1:0] SRC_LD    = CNT_W'(SRC_WAIT - 1);
    localparam logic [CNT_W-1:0] SETTLE_LD = CNT_W'(SETTLE_WAIT - 1);
    localparam logic [CNT_W-1:0] LOCK_LD   = CNT_W'(LOCK_TIMEOUT - 1);

    typedef struct packed {
        seq_state_e       st;
        logic             clken;
        logic             pwren;
        logic [SRC_W-1:0] src;
        logic [SRC_W-1:0] src_lat;
        logic [CFG_W-1:0] cfg;
        logic [CFG_W-1:0] cfg_lat;
        logic             cfg_wr;
        logic [DIV_W-1:0] div;
        logic [DIV_W-1:0] fin_lat;
        logic [DIV_W-1:0] up_lat;
        logic             meas_req;
        logic             done;
        logic             err;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic accept;

    assign accept = start_i &&
                    ((ctl_q.st == ST_IDLE) || (ctl_q.st == ST_DONE) || (ctl_q.st == ST_ERR));

    always_comb begin
        ctl_d        = ctl_q;
        ctl_d.cfg_wr = 1'b0;
        tmr_load_o   = 1'b0;
        tmr_val_o    = '0;

        unique case (ctl_q.st)
            ST_IDLE, ST_DONE, ST_ERR: begin
                if (accept) begin
                    ctl_d.src_lat = src_sel_i;
                    ctl_d.cfg_lat = cfg_word_i;
                    ctl_d.fin_lat = final_div_i;
                    ctl_d.up_lat  = div_up_i;
                    ctl_d.clken   = 1'b0;
                    ctl_d.done    = 1'b0;
                    ctl_d.err     = 1'b0;
                    ctl_d.st      = ST_BYPASS;
                    tmr_load_o    = 1'b1;
                    tmr_val_o     = BYP_LD;
                end
            end
            ST_BYPASS: begin
                if (tmr_zero_i) begin
                    ctl_d.pwren = 1'b0;
                    ctl_d.st    = ST_PWRDN;
                    tmr_load_o  = 1'b1;
                    tmr_val_o   = PWR_LD;
                end
            end
            ST_PWRDN: begin
                if (tmr_zero_i) begin
                    ctl_d.src  = ctl_q.src_lat;
                    ctl_d.st   = ST_SRC;
                    tmr_load_o = 1'b1;
                    tmr_val_o  = SRC_LD;
                end
            end
            ST_SRC: begin
                if (tmr_zero_i) begin
                    ctl_d.div = '0;
                    ctl_d.st  = ST_PROG;
                end
            end
            ST_PROG: begin
                ctl_d.cfg    = ctl_q.cfg_lat;
                ctl_d.cfg_wr = 1'b1;
                ctl_d.pwren  = 1'b1;
                ctl_d.st     = ST_LOCK;
                tmr_load_o   = 1'b1;
                tmr_val_o    = LOCK_LD;
            end
            ST_LOCK: begin
                if (lock_i) begin
                    ctl_d.meas_req = 1'b1;
                    ctl_d.st       = ST_CHECK;
                end else if (tmr_zero_i) begin
                    ctl_d.err = 1'b1;
                    ctl_d.st  = ST_ERR;
                end
            end
            ST_CHECK: begin
                if (meas_done_i) begin
                    ctl_d.meas_req = 1'b0;
                    if (meas_ok_i) begin
                        ctl_d.div = ctl_q.up_lat;
                        ctl_d.st  = ST_SWITCH;
                    end else begin
                        ctl_d.err = 1'b1;
                        ctl_d.st  = ST_ERR;
                    end
                end
            end
            ST_SWITCH: begin
                ctl_d.clken = 1'b1;
                ctl_d.st    = ST_SETTLE;
                tmr_load_o  = 1'b1;
                tmr_val_o   = SETTLE_LD;
            end
            ST_SETTLE: begin
                if (tmr_zero_i) begin
                    ctl_d.div  = ctl_q.fin_lat;
                    ctl_d.done = 1'b1;
                    ctl_d.st   = ST_DONE;
                end
            end
            default: begin
                ctl_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign pll_clken_o  = ctl_q.clken;
    assign pll_pwren_o  = ctl_q.pwren;
    assign ref_src_o    = ctl_q.src;
    assign pll_cfg_o    = ctl_q.cfg;
    assign pll_cfg_wr_o = ctl_q.cfg_wr;
    assign sys_div_o    = ctl_q.div;
    assign meas_req_o   = ctl_q.meas_req;
    assign done_o       = ctl_q.done;
    assign err_o        = ctl_q.err;
    assign busy_o       = (ctl_q.st != ST_IDLE) && (ctl_q.st != ST_DONE) && (ctl_q.st != ST_ERR);

    // R8: PLL output never selected while the PLL is unpowered
    p_clken_pwr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pll_clken_o |-> pll_pwren_o);

    // R4: source only moves with the PLL bypassed and powered down
    p_src_safe_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ref_src_o) |-> (!pll_clken_o && !pll_pwren_o));

    // R5: configuration strobe is a single cycle
    p_cfg_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pll_cfg_wr_o |=> !pll_cfg_wr_o);

    // R5: the write happens with divide-by-1 and power enabled
    p_cfg_ctx_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pll_cfg_wr_o |-> (pll_pwren_o && (sys_div_o == '0) && !pll_clken_o));

    // R7: an error leaves the PLL bypassed
    p_err_bypass_r7: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> !pll_clken_o);

    // R9: completion coincides with the target divider
    p_done_div_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> (sys_div_o == ctl_q.fin_lat));

    // R10: stepped code never below the target
    p_up_sat_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (ctl_q.up_lat >= ctl_q.fin_lat));

    // R11: a start while busy leaves latched settings untouched
    p_busy_ignore_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> ($stable(ctl_q.cfg_lat) && $stable(ctl_q.fin_lat) && $stable(ctl_q.src_lat)));

    // R12: flags exclusive
    p_flags_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && err_o));

endmodule

// File: rtl/clk_switch_seq.sv
module clk_switch_seq
    import clk_seq_pkg::*;
#(
    parameter int SRC_W        = 2,
    parameter int MULT_W       = 7,
    parameter int REFDIV_W     = 5,
    parameter int ODIV_W       = 3,
    parameter int DIV_W        = 6,
    parameter int BYPASS_WAIT  = 120,
    parameter int PWRDN_WAIT   = 60,
    parameter int SRC_WAIT     = 300,
    parameter int SETTLE_WAIT  = 200,
    parameter int LOCK_TIMEOUT = 65535
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              start_i,
    input  logic [SRC_W-1:0]                  src_sel_i,
    input  logic [MULT_W-1:0]                 mult_i,
    input  logic [REFDIV_W-1:0]               refdiv_i,
    input  logic [ODIV_W-1:0]                 odiv_i,
    input  logic [DIV_W-1:0]                  final_div_i,
    input  logic                              lock_i,
    input  logic                              meas_done_i,
    input  logic                              meas_ok_i,
    output logic                              pll_clken_o,
    output logic                              pll_pwren_o,
    output logic [SRC_W-1:0]                  ref_src_o,
    output logic [MULT_W+REFDIV_W+ODIV_W-1:0] pll_cfg_o,
    output logic                              pll_cfg_wr_o,
    output logic [DIV_W-1:0]                  sys_div_o,
    output logic                              meas_req_o,
    output logic                              busy_o,
    output logic                              done_o,
    output logic                              err_o
);

    localparam int CFG_W   = MULT_W + REFDIV_W + ODIV_W;
    localparam int CNT_MAX = int'(umax(umax(umax(BYPASS_WAIT, PWRDN_WAIT), umax(SRC_WAIT, SETTLE_WAIT)),
                                       LOCK_TIMEOUT));
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    logic [DIV_W-1:0] div_up;
    logic [CFG_W-1:0] cfg_word;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_zero;

    clk_seq_divcalc #(
        .DIV_W    (DIV_W),
        .MULT_W   (MULT_W),
        .REFDIV_W (REFDIV_W),
        .ODIV_W   (ODIV_W)
    ) u_divcalc (
        .final_div_i (final_div_i),
        .mult_i      (mult_i),
        .refdiv_i    (refdiv_i),
        .odiv_i      (odiv_i),
        .div_up_o    (div_up),
        .cfg_word_o  (cfg_word)
    );

    clk_seq_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .zero_o     (tmr_zero)
    );

    clk_seq_ctrl #(
        .SRC_W        (SRC_W),
        .CFG_W        (CFG_W),
        .DIV_W        (DIV_W),
        .CNT_W        (CNT_W),
        .BYPASS_WAIT  (BYPASS_WAIT),
        .PWRDN_WAIT   (PWRDN_WAIT),
        .SRC_WAIT     (SRC_WAIT),
        .SETTLE_WAIT  (SETTLE_WAIT),
        .LOCK_TIMEOUT (LOCK_TIMEOUT)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .src_sel_i    (src_sel_i),
        .cfg_word_i   (cfg_word),
        .final_div_i  (final_div_i),
        .div_up_i     (div_up),
        .lock_i       (lock_i),
        .meas_done_i  (meas_done_i),
        .meas_ok_i    (meas_ok_i),
        .tmr_zero_i   (tmr_zero),
        .tmr_load_o   (tmr_load),
        .tmr_val_o    (tmr_val),
        .pll_clken_o  (pll_clken_o),
        .pll_pwren_o  (pll_pwren_o),
        .ref_src_o    (ref_src_o),
        .pll_cfg_o    (pll_cfg_o),
        .pll_cfg_wr_o (pll_cfg_wr_o),
        .sys_div_o    (sys_div_o),
        .meas_req_o   (meas_req_o),
        .busy_o       (busy_o),
        .done_o       (done_o),
        .err_o        (err_o)
    );

endmodule

// File: tb/clk_switch_seq_tb.sv
`timescale 1ns/1ps
module clk_switch_seq_tb;

    localparam int SRC_W = 2, MULT_W = 7, REFDIV_W = 5, ODIV_W = 3, DIV_W = 3;
    localparam int BW = 120, PW = 60, SW = 300, STW = 200, TO = 40;
    localparam int CFG_W = MULT_W + REFDIV_W + ODIV_W;
    localparam int DMAX = (1 << DIV_W) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [SRC_W-1:0] src_sel = '0;
    logic [MULT_W-1:0] mult = '0;
    logic [REFDIV_W-1:0] refdiv = '0;
    logic [ODIV_W-1:0] odiv = '0;
    logic [DIV_W-1:0] fdiv = '0;
    logic lock = 1'b0, mdone = 1'b0, mok = 1'b0;
    logic clken, pwren, cfg_wr, mreq, busy, done, err;
    logic [SRC_W-1:0] rsrc;
    logic [CFG_W-1:0] cfg;
    logic [DIV_W-1:0] sdiv;

    clk_switch_seq #(
        .SRC_W(SRC_W), .MULT_W(MULT_W), .REFDIV_W(REFDIV_W), .ODIV_W(ODIV_W), .DIV_W(DIV_W),
        .BYPASS_WAIT(BW), .PWRDN_WAIT(PW), .SRC_WAIT(SW), .SETTLE_WAIT(STW), .LOCK_TIMEOUT(TO)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .src_sel_i(src_sel), .mult_i(mult),
        .refdiv_i(refdiv), .odiv_i(odiv), .final_div_i(fdiv), .lock_i(lock),
        .meas_done_i(mdone), .meas_ok_i(mok), .pll_clken_o(clken), .pll_pwren_o(pwren),
        .ref_src_o(rsrc), .pll_cfg_o(cfg), .pll_cfg_wr_o(cfg_wr), .sys_div_o(sdiv),
        .meas_req_o(mreq), .busy_o(busy), .done_o(done), .err_o(err)
    );

    always #2.5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int tests = 0, fails = 0;

    task automatic chk(input string what, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", what, act, exp);
        end
    endtask

    // event recorder and PLL / comparator stubs
    int t_clk_fall, t_clk_rise, t_pwr_fall, t_pwr_rise, t_src, t_cfgwr, t_mreq, t_done, t_err;
    logic [CFG_W-1:0] cfg_seen;
    int probe_cyc [6];
    int probe_val [6];
    logic p_clk = 1'b0, p_pwr = 1'b0, p_mreq = 1'b0, p_done = 1'b0, p_err = 1'b0;
    logic [SRC_W-1:0] p_src = '0;
    int lock_lat = 0, lock_cnt = 0, meas_lat = 0, meas_cnt = 0;
    bit lock_arm = 0, meas_arm = 0, meas_ok_cfg = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (p_clk && !clken) t_clk_fall = cyc;
            if (!p_clk && clken) t_clk_rise = cyc;
            if (p_pwr && !pwren) t_pwr_fall = cyc;
            if (!p_pwr && pwren) t_pwr_rise = cyc;
            if (rsrc != p_src) t_src = cyc;
            if (cfg_wr && t_cfgwr < 0) begin t_cfgwr = cyc; cfg_seen = cfg; end
            if (!p_mreq && mreq) t_mreq = cyc;
            if (!p_done && done) t_done = cyc;
            if (!p_err && err) t_err = cyc;
            for (int k = 0; k < 6; k++) if (cyc == probe_cyc[k]) probe_val[k] = int'(sdiv);
            if (cfg_wr) begin
                if (lock_lat == 0) lock = 1'b1;
                else begin lock_cnt = lock_lat - 1; lock_arm = 1; end
            end else if (lock_arm) begin
                if (lock_cnt == 0) begin lock = 1'b1; lock_arm = 0; end
                else lock_cnt--;
            end
            if (!mreq) begin
                mdone = 1'b0; meas_arm = 0;
            end else if (!p_mreq) begin
                if (meas_lat == 0) begin mdone = 1'b1; mok = meas_ok_cfg; end
                else begin meas_cnt = meas_lat - 1; meas_arm = 1; end
            end else if (meas_arm) begin
                if (meas_cnt == 0) begin mdone = 1'b1; mok = meas_ok_cfg; meas_arm = 0; end
                else meas_cnt--;
            end
        end
        p_clk = clken; p_pwr = pwren; p_mreq = mreq; p_done = done; p_err = err; p_src = rsrc;
    end

    task automatic run_seq(input logic [SRC_W-1:0] s, input logic [MULT_W-1:0] m,
                           input logic [REFDIV_W-1:0] r, input logic [ODIV_W-1:0] o,
                           input logic [DIV_W-1:0] f, input int lat, input int dly,
                           input bit ok, input bit inject);
        bit pc, pp;
        logic [SRC_W-1:0] ps;
        int pd, st, e_div1, e_cfg, e_up, e_fin, up, n;
        @(negedge clk);
        pc = clken; pp = pwren; ps = rsrc; pd = int'(sdiv);
        t_clk_fall = -1; t_clk_rise = -1; t_pwr_fall = -1; t_pwr_rise = -1; t_src = -1;
        t_cfgwr = -1; t_mreq = -1; t_done = -1; t_err = -1;
        lock = 1'b0; lock_arm = 0; lock_lat = lat; meas_lat = dly; meas_ok_cfg = ok;
        src_sel = s; mult = m; refdiv = r; odiv = o; fdiv = f; start = 1'b1;
        st = cyc + 1;
        e_div1 = st + BW + PW + SW;
        e_cfg = e_div1 + 1;
        e_up = e_cfg + lat + 1 + dly + 1;
        e_fin = e_up + 1 + STW;
        up = (int'(f) == DMAX) ? DMAX : int'(f) + 1;
        probe_cyc[0] = e_div1 - 1; probe_cyc[1] = e_div1; probe_cyc[2] = e_up - 1;
        probe_cyc[3] = e_up; probe_cyc[4] = e_fin - 1; probe_cyc[5] = e_fin;
        for (int k = 0; k < 6; k++) probe_val[k] = -1;
        @(negedge clk);
        start = 1'b0;
        chk("R2 busy after start", busy, 1);
        chk("R2 done cleared", done, 0);
        chk("R2 error cleared", err, 0);
        if (inject) begin
            repeat (200) @(negedge clk);
            src_sel = ~s; mult = ~m; refdiv = ~r; odiv = ~o; fdiv = ~f; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        n = 0;
        while (!done && !err && n < 3000) begin @(negedge clk); n++; end
        @(negedge clk);
        if (pc) chk("R2 clock enable cleared at start", t_clk_fall, st);
        if (pp) chk("R3 power-down delay", t_pwr_fall, st + BW);
        if (ps != s) chk("R4 source change delay", t_src, st + BW + PW);
        else chk("R4 source unchanged", t_src, -1);
        chk("R4 source value", int'(rsrc), int'(s));
        if (pd != 0) chk("R5 divider held before /1", probe_val[0], pd);
        chk("R5 divider /1 before program", probe_val[1], 0);
        chk("R5 config write cycle", t_cfgwr, e_cfg);
        chk("R5 config word packing", int'(cfg_seen), int'({o, r, m}));
        chk("R5 power-up with write", t_pwr_rise, e_cfg);
        if (inject) chk("R11 busy start ignored, word kept", int'(cfg_seen), int'({o, r, m}));
        if (lat < TO) begin
            chk("R6 lock to comparator request", t_mreq, e_cfg + lat + 1);
            if (ok) begin
                chk("R8 divider /1 until verdict", probe_val[2], 0);
                if (int'(f) == DMAX) chk("R10 saturated step", probe_val[3], DMAX);
                else chk("R8 one-above step", probe_val[3], int'(f) + 1);
                chk("R8 clock enable after step", t_clk_rise, e_up + 1);
                chk("R9 stepped divider through settle", probe_val[4], up);
                chk("R9 final divider", probe_val[5], int'(f));
                chk("R9 done time", t_done, e_fin);
                chk("R12 no error on success", t_err, -1);
                if (inject) chk("R11 busy start ignored, target kept", int'(sdiv), int'(f));
            end else begin
                chk("R7 error on bad frequency", t_err, e_up);
                chk("R7 no switch to PLL", t_clk_rise, -1);
                chk("R7 divider kept /1", int'(sdiv), 0);
                chk("R7 request dropped", mreq, 0);
                chk("R12 no done on failure", done, 0);
            end
        end else begin
            chk("R6 lock timeout", t_err, e_cfg + TO);
            chk("R6 no comparator request", t_mreq, -1);
            chk("R6 PLL left bypassed", clken, 0);
        end
    endtask

    task automatic hold_check(input int exp_done, input int exp_err);
        repeat (50) @(negedge clk);
        chk("R12 done flag holds", done, exp_done);
        chk("R12 error flag holds", err, exp_err);
        chk("R12 idle while holding", busy, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog: got %0d expected %0d", cyc, 0);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 clock enable", clken, 0);
        chk("R1 power enable", pwren, 0);
        chk("R1 source", int'(rsrc), 0);
        chk("R1 divider /1", int'(sdiv), 0);
        chk("R1 config word", int'(cfg), 0);
        chk("R1 write strobe", cfg_wr, 0);
        chk("R1 comparator request", mreq, 0);
        repeat (20) @(negedge clk);
        chk("R1 idle without start", busy, 0);
        chk("R1 no flags", int'({done, err}), 0);

        run_seq(2'd1, 7'd20, 5'd1, 3'd1, 3'd3, 5, 2, 1'b1, 1'b0);
        hold_check(1, 0);

        for (int f = 0; f <= DMAX; f++)
            run_seq(SRC_W'(f % 4), MULT_W'(f * 9 + 1), REFDIV_W'(f), ODIV_W'(f),
                    DIV_W'(f), f * 5, f, 1'b1, 1'b0);

        run_seq(2'd3, 7'd50, 5'd2, 3'd2, 3'd2, 3, 4, 1'b0, 1'b0);
        hold_check(0, 1);
        run_seq(2'd0, 7'd33, 5'd3, 3'd1, 3'd5, 0, 0, 1'b1, 1'b0);

        run_seq(2'd2, 7'd64, 5'd4, 3'd3, 3'd1, TO, 1, 1'b1, 1'b0);
        hold_check(0, 1);
        run_seq(2'd1, 7'd65, 5'd5, 3'd4, 3'd1, TO - 1, 1, 1'b1, 1'b0);

        run_seq(2'd3, 7'd77, 5'd6, 3'd5, 3'd4, 7, 3, 1'b1, 1'b1);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule